// File: doc/BRIEF.md
# Split SRAM / Direct-Mapped Instruction Memory

This block is a level-one program memory holding 32KB in a single physical array. A 3-bit mode register decides how much of that array is plain addressable SRAM and how much serves as a direct-mapped instruction cache. The SRAM always sits at the low end of the block's address window, which starts at 0x00E0_0000 and covers 32KB. The cache always takes the top of the array. Instruction fetches arrive on a valid/ready address port. A fetch that lands in the SRAM window is read straight from the array. Any other fetch goes through the cache tags. A miss sends a line-fill request to a next-level memory port, and the block then collects the line one 32-bit word per beat.

Reset selects the all-cache mode. Software may later write a new mode through a small configuration port. Each accepted mode write invalidates every cache line and stalls fetches for one cycle. When the cache size is zero, fetches outside the SRAM window are passed through to the next level and nothing is kept.

The controller has four states. IDLE accepts fetches and mode writes. FLUSH is the single stall cycle after a mode write. REQ holds the line request until the next level accepts it. FILL receives the beats. The transitions are:
- IDLE to FLUSH on an accepted mode write.
- IDLE to REQ on an accepted fetch that needs the next level.
- FLUSH to IDLE unconditionally.
- REQ to FILL when the request is accepted.
- FILL to IDLE on the final beat.

Top module: `imem_configurable`

## Requirements
- R1: After reset the mode is all-cache (100) and no line is valid. `fetch_ready` and `cfg_ready` are high, and `rsp_valid` and `mem_req_valid` are low.
- R2: The mode sets the cache size: 000 gives 0KB, 001 gives 4KB, 010 gives 8KB, 011 gives 16KB and 100 gives 32KB. The SRAM window is the address range from 0x00E0_0000 up to, but not including, 0x00E0_8000 minus the cache size.
- R3: A fetch accepted inside the SRAM window returns its word on `rsp_valid` in the cycle right after acceptance, and issues no next-level request.
- R4: A fetch outside the SRAM window that hits a valid line with a matching tag returns its word in the cycle right after acceptance, and issues no next-level request.
- R5: On a miss, `mem_req_valid` rises the cycle after acceptance. It carries the fetch address with bits 4:0 cleared and holds that address until `mem_req_ready`. The line then arrives as 8 beats in ascending word order. The requested word (address bits 4:2) is returned in the cycle after the final beat.
- R6: The cache is direct-mapped with 32-byte lines. The set is the line number (address bits above 4) modulo the number of cache lines, and the physical line is the SRAM line count plus the set. Two addresses whose sets are equal evict each other.
- R7: A mode write is accepted when `cfg_we` and `cfg_ready` are both high. It clears every valid bit, and `fetch_ready` is low for exactly the one following cycle.
- R8: Mode codes 101, 110 and 111 behave exactly as 100.
- R9: With a cache size of zero, a fetch outside the SRAM window issues a line request and returns the requested word, but stores nothing. Repeating the fetch issues a new request.
- R10: Cache and SRAM share one array. After a mode change, an SRAM fetch of a physical line returns the words that a cache fill last wrote into that line.
- R11: A mode write while `cfg_ready` is low, that is during a line request or fill, is ignored. The mode and the valid lines are unchanged.
- R12: While a line request or fill is in progress, `fetch_ready` is low. Each accepted fetch produces exactly one response, and responses come in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | New mode code |
| cfg_ready | output | 1 | Mode write can be accepted |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | 32 | Fetch byte address (word aligned) |
| fetch_ready | output | 1 | Fetch can be accepted |
| rsp_valid | output | 1 | Fetch data valid (one cycle) |
| rsp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_addr | output | 32 | Line-aligned request address |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_rsp_valid | input | 1 | Line beat valid |
| mem_rsp_data | input | 32 | Line beat data |

## Verification
The bench builds the block with its default parameters: a 32KB array, 32-byte lines, 32-bit words and base address 0x00E0_0000. With these values every mode boundary falls at its real address: 0x00E0_7000, 0x00E0_6000, 0x00E0_4000 and the end of the block at 0x00E0_8000. The bench probes the word just below and just above each boundary. With 1024 lines in all-cache mode and 128 lines in the 4KB mode, two addresses 4KB apart collide in one mode and coexist in the other. That makes the set count that the mode decode produces visible at the ports. The next-level model holds off its ready for one cycle and inserts a gap between beats 3 and 4, so the bench also covers a held request and a stalled fill.

// File: rtl/imem_cfg_pkg.sv
package imem_cfg_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FLUSH = 2'd1,
        S_REQ   = 2'd2,
        S_FILL  = 2'd3
    } imem_state_e;

    localparam logic [2:0] MODE_ALL_CACHE = 3'b100;

endpackage

// File: rtl/imem_mode_decode.sv
module imem_mode_decode #(
    parameter int NUM_LINES = 1024,
    parameter int CNT_W     = 11
) (
    input  logic [2:0]       mode,
    output logic [CNT_W-1:0] cache_lines,
    output logic [CNT_W-1:0] sram_lines
);

    always_comb begin
        unique case (mode)
            3'b000:  cache_lines = '0;
            3'b001:  cache_lines = CNT_W'(NUM_LINES / 8);
            3'b010:  cache_lines = CNT_W'(NUM_LINES / 4);
            3'b011:  cache_lines = CNT_W'(NUM_LINES / 2);
            default: cache_lines = CNT_W'(NUM_LINES);
        endcase
        sram_lines = CNT_W'(NUM_LINES) - cache_lines;
    end

endmodule

// File: rtl/imem_tag_store.sv
module imem_tag_store #(
    parameter int NUM_LINES = 1024,
    parameter int IDX_W     = 10,
    parameter int LADDR_W   = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [IDX_W-1:0]     look_idx,
    input  logic [LADDR_W-1:0]   look_tag,
    output logic                 hit,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LADDR_W-1:0]   wr_tag,
    output logic [NUM_LINES-1:0] valid_vec
);

    logic [LADDR_W-1:0] tags [NUM_LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_vec <= '0;
        end else if (clear) begin
            valid_vec <= '0;
        end else if (wr_en) begin
            valid_vec[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_tag;
        end
    end

    assign hit = valid_vec[look_idx] && (tags[look_idx] == look_tag);

endmodule

// File: rtl/imem_data_array.sv
module imem_data_array #(
    parameter int NUM_LINES = 1024,
    parameter int WPL       = 8,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 10,
    parameter int WSEL_W    = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_line,
    input  logic [WSEL_W-1:0] w_word,
    input  logic [DATA_W-1:0] w_data,
    input  logic [IDX_W-1:0]  r_line,
    input  logic [WSEL_W-1:0] r_word,
    output logic [DATA_W-1:0] r_data
);

    localparam int LINE_W = WPL * DATA_W;

    logic [LINE_W-1:0] lines [NUM_LINES];

    always_ff @(posedge clk) begin
        if (we) begin
            lines[w_line][w_word*DATA_W +: DATA_W] <= w_data;
        end
    end

    assign r_data = lines[r_line][r_word*DATA_W +: DATA_W];

endmodule

// File: rtl/imem_configurable.sv
module imem_configurable
    import imem_cfg_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 32,
    parameter int              BLOCK_BYTES = 32768,
    parameter int              LINE_BYTES  = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h00E0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    output logic              cfg_ready,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int NUM_LINES  = BLOCK_BYTES / LINE_BYTES;
    localparam int WPL        = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BSEL_W     = $clog2(WORD_BYTES);
    localparam int WSEL_W     = $clog2(WPL);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int LADDR_W    = ADDR_W - OFF_W;
    localparam int CNT_W      = IDX_W + 1;

    // ---------------------------------------------------------------
    // Mode register and decode
    // ---------------------------------------------------------------
    logic [2:0]       mode_q;
    logic [CNT_W-1:0] cache_lines;
    logic [CNT_W-1:0] sram_lines;

    imem_mode_decode #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W)
    ) u_decode (
        .mode        (mode_q),
        .cache_lines (cache_lines),
        .sram_lines  (sram_lines)
    );

    imem_state_e state_q, state_d;

    // ---------------------------------------------------------------
    // Address classification for the incoming fetch
    // ---------------------------------------------------------------
    logic [ADDR_W-1:0]  f_offset;
    logic               f_in_block;
    logic               f_in_sram;
    logic [LADDR_W-1:0] f_laddr;
    logic [LADDR_W-1:0] f_line_off;
    logic [IDX_W-1:0]   f_set;
    logic [IDX_W-1:0]   f_phys;
    logic [IDX_W-1:0]   r_line;
    logic [WSEL_W-1:0]  f_word;
    logic               cache_on;

    always_comb begin
        f_offset   = fetch_addr - BASE_ADDR;
        f_in_block = (fetch_addr >= BASE_ADDR) && (f_offset < ADDR_W'(BLOCK_BYTES));
        f_line_off = f_offset[ADDR_W-1:OFF_W];
        f_in_sram  = f_in_block && (f_line_off < LADDR_W'(sram_lines));
        f_laddr    = fetch_addr[ADDR_W-1:OFF_W];
        f_set      = IDX_W'(f_laddr & LADDR_W'(cache_lines - 1'b1));
        f_phys     = IDX_W'(sram_lines) + f_set;
        f_word     = fetch_addr[OFF_W-1:BSEL_W];
        cache_on   = (cache_lines != '0);
        r_line     = f_in_sram ? IDX_W'(f_line_off) : f_phys;
    end

    // ---------------------------------------------------------------
    // Tags and data
    // ---------------------------------------------------------------
    logic                 hit;
    logic                 need_fill;
    logic                 accept;
    logic                 cfg_take;
    logic [NUM_LINES-1:0] line_valid;
    logic [DATA_W-1:0]    arr_rdata;

    logic [LADDR_W-1:0]   miss_laddr;
    logic [WSEL_W-1:0]    miss_word;
    logic [IDX_W-1:0]     miss_phys;
    logic                 miss_cached;
    logic [WSEL_W-1:0]    beat_q;
    logic [DATA_W-1:0]    hold_q;
    logic                 fill_beat;
    logic                 fill_last;

    assign fill_beat = (state_q == S_FILL) && mem_rsp_valid;
    assign fill_last = fill_beat && (beat_q == WSEL_W'(WPL - 1));

    imem_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .LADDR_W   (LADDR_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_take),
        .look_idx  (f_phys),
        .look_tag  (f_laddr),
        .hit       (hit),
        .wr_en     (fill_last && miss_cached),
        .wr_idx    (miss_phys),
        .wr_tag    (miss_laddr),
        .valid_vec (line_valid)
    );

    imem_data_array #(
        .NUM_LINES (NUM_LINES),
        .WPL       (WPL),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .WSEL_W    (WSEL_W)
    ) u_array (
        .clk    (clk),
        .we     (fill_beat && miss_cached),
        .w_line (miss_phys),
        .w_word (beat_q),
        .w_data (mem_rsp_data),
        .r_line (r_line),
        .r_word (f_word),
        .r_data (arr_rdata)
    );

    assign need_fill = !f_in_sram && !(cache_on && hit);
    assign accept    = fetch_valid && fetch_ready;
    assign cfg_take  = cfg_we && cfg_ready;

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cfg_take) begin
                    state_d = S_FLUSH;
                end else if (accept && need_fill) begin
                    state_d = S_REQ;
                end
            end
            S_FLUSH: state_d = S_IDLE;
            S_REQ: begin
                if (mem_req_ready) begin
                    state_d = S_FILL;
                end
            end
            S_FILL: begin
                if (fill_last) begin
                    state_d = S_IDLE;
                end
            end
        endcase
    end

    // ---------------------------------------------------------------
    // Output logic
    // ---------------------------------------------------------------
    always_comb begin
        cfg_ready     = (state_q == S_IDLE);
        fetch_ready   = (state_q == S_IDLE) && !cfg_we;
        mem_req_valid = (state_q == S_REQ);
        mem_req_addr  = {miss_laddr, {OFF_W{1'b0}}};
    end

    // ---------------------------------------------------------------
    // Mode register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ALL_CACHE;
        end else if (cfg_take) begin
            mode_q <= cfg_mode;
        end
    end

    // ---------------------------------------------------------------
    // Miss bookkeeping and beat counter
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_laddr  <= '0;
            miss_word   <= '0;
            miss_phys   <= '0;
            miss_cached <= 1'b0;
            beat_q      <= '0;
            hold_q      <= '0;
        end else begin
            if (accept && need_fill) begin
                miss_laddr  <= f_laddr;
                miss_word   <= f_word;
                miss_phys   <= f_phys;
                miss_cached <= cache_on;
                beat_q      <= '0;
            end else if (fill_beat) begin
                beat_q <= beat_q + 1'b1;
            end
            if (fill_beat && (beat_q == miss_word)) begin
                hold_q <= mem_rsp_data;
            end
        end
    end

    // ---------------------------------------------------------------
    // Response register
    // ---------------------------------------------------------------
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else if (accept && !need_fill) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= arr_rdata;
        end else if (fill_last) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= (beat_q == miss_word) ? mem_rsp_data : hold_q;
        end else begin
            rsp_valid_q <= 1'b0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/imem_configurable_chk.sv
module imem_configurable_chk #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 5,
    parameter int NUM_LINES = 1024
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch_valid,
    input logic                 fetch_ready,
    input logic                 need_fill,
    input logic                 rsp_valid,
    input logic                 cfg_we,
    input logic                 cfg_ready,
    input logic                 mem_req_valid,
    input logic                 mem_req_ready,
    input logic [ADDR_W-1:0]    mem_req_addr,
    input logic [NUM_LINES-1:0] line_valid
);

    AST_FAST_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && !need_fill) |=> rsp_valid); // R3 R4

    AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && need_fill) |=> (mem_req_valid && !rsp_valid)); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5

    AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R5

    AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_ready) |=> (!fetch_ready && ($countones(line_valid) == 0))); // R7

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (!fetch_ready && !cfg_ready)); // R12

endmodule

bind imem_configurable imem_configurable_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_ready   (fetch_ready),
    .need_fill     (need_fill),
    .rsp_valid     (rsp_valid),
    .cfg_we        (cfg_we),
    .cfg_ready     (cfg_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .line_valid    (line_valid)
);

// File: tb/imem_configurable_test.sv
module imem_configurable_test;
    timeunit 1ns;
    timeprecision 10ps;

    localparam logic [31:0] BASE = 32'h00E0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = 3'b000;
    logic        cfg_ready;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    imem_configurable uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_mode      (cfg_mode),
        .cfg_ready     (cfg_ready),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_ready   (fetch_ready),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    typedef struct {
        logic [31:0] data;
        bit          care;
        string       req;
    } exp_t;

    exp_t        expq[$];
    int          tests = 0;
    int          fails = 0;
    int          reqs  = 0;
    logic [31:0] last_req = '0;

    function automatic logic [31:0] memword(input logic [31:0] a);
        return a ^ 32'hC3A5_5A3C;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop expected responses in order.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R12 unexpected response", rsp_data, 32'h0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.care) check(rsp_data == e.data, e.req, rsp_data, e.data);
            end
        end
    end

    // Next-level memory model: one cycle of ready delay, gap after beat 3.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [31:0] la;
                @(negedge clk);
                mem_req_ready = 1'b1;
                la = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                reqs++;
                last_req = la;
                for (int b = 0; b < 8; b++) begin
                    @(negedge clk);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memword(la + 32'(4 * b));
                    if (b == 3) begin
                        @(negedge clk);
                        mem_rsp_valid = 1'b0;
                    end
                end
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Driver: push the expected item, then present the fetch until accepted.
    task automatic fetch(input logic [31:0] a, input logic [31:0] d, input bit care,
                         input string req);
        exp_t e;
        e.data = d;
        e.care = care;
        e.req  = req;
        expq.push_back(e);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        #0.1;
        while (!fetch_ready) begin
            @(negedge clk);
            #0.1;
        end
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (expq.size() != 0 || !fetch_ready);
    endtask

    task automatic fetch_chk(input logic [31:0] a, input bit care, input int dreq,
                             input string req);
        int r0;
        r0 = reqs;
        fetch(a, memword(a), care, req);
        wait_idle();
        check(reqs == r0 + dreq, req, 32'(reqs - r0), 32'(dreq));
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_mode = m;
        #0.1;
        check(cfg_ready, "R7 cfg_ready in idle", 32'(cfg_ready), 32'h1);
        @(negedge clk);
        cfg_we = 1'b0;
        #0.1;
        check(!fetch_ready, "R7 stall cycle", 32'(fetch_ready), 32'h0);
        @(negedge clk);
        #0.1;
        check(fetch_ready, "R7 stall ends after one cycle", 32'(fetch_ready), 32'h1);
    endtask

    localparam logic [31:0] A = 32'h0020_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fetch_ready && cfg_ready, "R1 ready after reset",
              {30'h0, fetch_ready, cfg_ready}, 32'h3);
        check(!rsp_valid && !mem_req_valid, "R1 idle outputs after reset",
              {30'h0, rsp_valid, mem_req_valid}, 32'h0);

        // Reset mode is all-cache: 1024 sets, A and A+4KB coexist (R1, R6)
        fetch_chk(A, 1'b1, 1, "R5 miss returns requested word");
        check(last_req == A, "R5 line request address", last_req, A);
        fetch_chk(A + 32'h14, 1'b1, 0, "R4 hit same line");
        fetch_chk(A + 32'h1000, 1'b1, 1, "R6 other set miss");
        fetch_chk(A, 1'b1, 0, "R1 all-cache keeps both lines");
        fetch_chk(32'h0020_201C, 1'b1, 1, "R5 last word of line");
        check(last_req == 32'h0020_2000, "R5 aligned request", last_req, 32'h0020_2000);

        // R11: mode write during a fill is ignored
        fetch(32'h0040_0008, memword(32'h0040_0008), 1'b1, "R11 miss data");
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_mode = 3'b000;
        #0.1;
        check(!cfg_ready, "R11 cfg_ready low while busy", 32'(cfg_ready), 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_idle();
        fetch_chk(32'h0040_0008, 1'b1, 0, "R11 line still valid after ignored write");

        // R10: fill at physical line 2, then read it as SRAM
        fetch_chk(32'h0010_0048, 1'b1, 1, "R10 fill in all-cache");
        set_mode(3'b000);
        begin
            int r0;
            r0 = reqs;
            fetch(BASE + 32'h48, memword(32'h0010_0048), 1'b1, "R10 shared array data");
            wait_idle();
            check(reqs == r0, "R3 SRAM fetch no request", 32'(reqs - r0), 32'h0);
        end

        // R9: no cache, pass-through every time
        fetch_chk(32'h0030_0004, 1'b1, 1, "R9 uncached fetch");
        fetch_chk(32'h0030_0004, 1'b1, 1, "R9 uncached refetch requests again");
        // R2 mode 000 boundary
        fetch_chk(BASE + 32'h7FFC, 1'b0, 0, "R2 mode000 top SRAM word");
        fetch_chk(BASE + 32'h8000, 1'b1, 1, "R2 mode000 above block");

        // Mode 001: 4KB cache, 128 sets
        set_mode(3'b001);
        fetch_chk(BASE + 32'h6FFC, 1'b0, 0, "R2 mode001 SRAM top");
        fetch_chk(BASE + 32'h7000, 1'b1, 1, "R2 mode001 cache region");
        fetch_chk(A, 1'b1, 1, "R6 mode001 miss A");
        fetch_chk(A + 32'h800, 1'b1, 1, "R6 mode001 miss C");
        fetch_chk(A, 1'b1, 0, "R6 mode001 hit A");
        fetch_chk(A + 32'h1000, 1'b1, 1, "R6 mode001 conflicting B");
        fetch_chk(A + 32'h800, 1'b1, 0, "R6 mode001 C survives");
        fetch_chk(A, 1'b1, 1, "R6 mode001 A evicted");

        // Mode 111 reserved behaves as all-cache
        set_mode(3'b111);
        fetch_chk(A, 1'b1, 1, "R7 flush forces miss");
        fetch_chk(A + 32'h1000, 1'b1, 1, "R8 reserved mode miss B");
        fetch_chk(A, 1'b1, 0, "R8 reserved mode 1024 sets");
        set_mode(3'b111);
        fetch_chk(A, 1'b1, 1, "R7 rewrite invalidates");

        // Modes 010 and 011 boundaries
        set_mode(3'b010);
        fetch_chk(BASE + 32'h5FFC, 1'b0, 0, "R2 mode010 SRAM top");
        fetch_chk(BASE + 32'h6000, 1'b1, 1, "R2 mode010 cache region");
        set_mode(3'b011);
        fetch_chk(BASE + 32'h3FFC, 1'b0, 0, "R2 mode011 SRAM top");
        fetch_chk(BASE + 32'h4000, 1'b1, 1, "R2 mode011 cache region");

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R12 every fetch answered", 32'(expq.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule